// File: doc/BRIEF.md
# Incrementing Pipeline Stage with Skid Buffer

This block is one registered stage of a data pipeline. Words move from a producer to a consumer under strobe/busy flow control, and the stage adds one to every word it forwards. The upstream side offers a word by raising its strobe. The stage takes that word on a clock edge unless it is asserting its own upstream busy output. The downstream side takes the presented word on any edge where the stage's downstream strobe is high and the consumer's busy input is low.

The stage has an output register and one extra skid register, so it can hold two words. The skid register catches the word that was already accepted in the cycle where the consumer began to stall. Upstream busy comes from a flop and is high exactly while the skid register holds a word. Identical stages chain directly: one stage's downstream strobe, data and busy connect to the next stage's upstream strobe, data and busy. Each stage adds one clock of latency.

Top module: `bp_skid_stage`

## Requirements
- R1: A synchronous active-low reset empties the stage. After any edge with `rst_n` low, `dn_stb_o` and `up_busy_o` are 0, and no word held before the reset is ever presented afterwards.
- R2: A word is accepted on an edge where `up_stb_i` is 1 and `up_busy_o` is 0. When the output register is empty or is being drained on that edge, `dn_stb_o` is 1 from that edge onward, which is one cycle of latency.
- R3: Every presented word equals its accepted input word plus one, modulo 2^DATA_W. An all-ones input comes out as zero.
- R4: A word is consumed on an edge where `dn_stb_o` is 1 and `dn_busy_i` is 0. If no other word is held or accepted on that edge, `dn_stb_o` is 0 after it.
- R5: While `dn_stb_o` and `dn_busy_i` are both 1, `dn_stb_o` stays 1 and `dn_data_o` keeps its value on the next cycle.
- R6: A word accepted while the output register is held by a stall goes into the skid register, and `up_busy_o` is 1 after that edge. While `up_busy_o` is 1, `up_stb_i` and `up_data_i` have no effect. `up_busy_o` stays 1 for as long as `dn_busy_i` stays 1.
- R7: When the stage holds two words and `dn_busy_i` falls, the older word is consumed on that edge. The skid word is then presented on the next cycle with `dn_strb_o` still 1, and `up_busy_o` returns to 0 after that same edge.
- R8: While `dn_busy_i` stays 0, the stage accepts and delivers one word per clock, and `up_busy_o` stays 0.
- R9: In two chained stages, a word offered at the chain input first raises the chain's downstream strobe two clocks later, carrying the input plus two.
- R10: Under random consumer stalls and random producer gaps, every accepted word comes out exactly once, in order, incremented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| up_stb_i | input | 1 | Producer offers a word |
| up_data_i | input | DATA_W | Word offered by the producer |
| up_busy_o | output | 1 | Stage refuses new words (skid register full) |
| dn_stb_o | output | 1 | Stage presents a word |
| dn_data_o | output | DATA_W | Presented word (input plus one) |
| dn_busy_i | input | 1 | Consumer stalls the stage |

## Verification
The hardest state to reach is a full stage: two words held, upstream busy high, and a stall that is then lifted. Reaching it needs the consumer to raise busy in exactly the cycle a fresh word is accepted behind a word that is already held. The vector table forces this in a fixed order. It also keeps the producer strobing with changing data while busy is high, then releases the stall and checks that the older word leaves first, the skid word follows and busy drops. A long random run with bursty stall rates then drives the same fill and release many times.

// File: rtl/bp_pkg.sv
// Package bp_pkg
// Shared types for the incrementing skid stage.
// Assumes: a stage holds at most two words.
package bp_pkg;

    // Number of words held by the stage.
    typedef enum logic [1:0] {
        OCC_NONE = 2'd0,
        OCC_ONE  = 2'd1,
        OCC_TWO  = 2'd2
    } occ_t;

endpackage

// File: rtl/bp_incr.sv
// Module bp_incr
// Applies the fixed datapath transform: adds one, wrapping at 2^DATA_W.
// Assumes: purely combinational, used at the entry of the stage.
module bp_incr #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_i,
    output logic [DATA_W-1:0] y_o
);

    localparam logic [DATA_W-1:0] STEP = DATA_W'(1);

    // Incremented word.
    always_comb begin
        y_o = a_i + STEP;
    end

endmodule

// File: rtl/bp_ctrl.sv
// Module bp_ctrl
// Occupancy controller. Decides when the output and skid registers load,
// and drives the registered strobe and busy flags.
// Assumes: the upstream is ignored while busy is high; skid data loads
// into the output only on a consume.
module bp_ctrl
    import bp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic up_stb_i,
    input  logic dn_busy_i,
    output logic ld_out_o,
    output logic out_from_skid_o,
    output logic ld_skid_o,
    output logic stb_o,
    output logic busy_o
);

    occ_t state_q, state_d;
    logic stb_q, busy_q;
    logic accept, consume;

    // Handshake events on the coming edge.
    always_comb begin
        accept  = up_stb_i & ~busy_q;
        consume = stb_q & ~dn_busy_i;
    end

    // Next occupancy and register load controls.
    always_comb begin
        state_d         = state_q;
        ld_out_o        = 1'b0;
        out_from_skid_o = 1'b0;
        ld_skid_o       = 1'b0;
        case (state_q)
            OCC_NONE: begin
                if (accept) begin
                    ld_out_o = 1'b1;
                    state_d  = OCC_ONE;
                end
            end
            OCC_ONE: begin
                if (consume) begin
                    if (accept) ld_out_o = 1'b1;
                    else        state_d  = OCC_NONE;
                end else if (accept) begin
                    ld_skid_o = 1'b1;
                    state_d   = OCC_TWO;
                end
            end
            OCC_TWO: begin
                if (consume) begin
                    ld_out_o        = 1'b1;
                    out_from_skid_o = 1'b1;
                    state_d         = OCC_ONE;
                end
            end
            default: state_d = OCC_NONE;
        endcase
    end

    // State and flag registers, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_NONE;
            stb_q   <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            stb_q   <= (state_d != OCC_NONE);
            busy_q  <= (state_d == OCC_TWO);
        end
    end

    assign stb_o  = stb_q;
    assign busy_o = busy_q;

    // R6
    skid_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> stb_q);

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && dn_busy_i |=> busy_q);

    // R7
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !dn_busy_i |=> !busy_q && stb_q);

    // R4
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q && !busy_q && !dn_busy_i && !up_stb_i |=> !stb_q);

endmodule

// File: rtl/bp_regs.sv
// Module bp_regs
// Data storage: the output register and the skid register.
// Assumes: load controls come from bp_ctrl; the incoming word is
// already transformed.
module bp_regs #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              ld_out_i,
    input  logic              out_from_skid_i,
    input  logic              ld_skid_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] out_o
);

    logic [DATA_W-1:0] out_q, skid_q;

    // Output register: takes the skid word or the fresh word.
    always_ff @(posedge clk) begin
        if (ld_out_i) out_q <= out_from_skid_i ? skid_q : word_i;
    end

    // Skid register: catches the word that arrives during a stall.
    always_ff @(posedge clk) begin
        if (ld_skid_i) skid_q <= word_i;
    end

    assign out_o = out_q;

endmodule

// File: rtl/bp_skid_stage.sv
// Module bp_skid_stage
// One pipeline stage with strobe/busy flow control. It adds one to every
// word and holds up to two words (output plus skid register).
// Assumes: the producer watches up_busy_o; synchronous active-low reset.
module bp_skid_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_stb_i,
    input  logic [DATA_W-1:0] up_data_i,
    output logic              up_busy_o,
    output logic              dn_stb_o,
    output logic [DATA_W-1:0] dn_data_o,
    input  logic              dn_busy_i
);

    logic [DATA_W-1:0] word_inc;
    logic              ld_out, out_from_skid, ld_skid;

    bp_incr #(.DATA_W(DATA_W)) u_incr (
        .a_i (up_data_i),
        .y_o (word_inc)
    );

    bp_ctrl u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .up_stb_i        (up_stb_i),
        .dn_busy_i       (dn_busy_i),
        .ld_out_o        (ld_out),
        .out_from_skid_o (out_from_skid),
        .ld_skid_o       (ld_skid),
        .stb_o           (dn_stb_o),
        .busy_o          (up_busy_o)
    );

    bp_regs #(.DATA_W(DATA_W)) u_regs (
        .clk             (clk),
        .ld_out_i        (ld_out),
        .out_from_skid_i (out_from_skid),
        .ld_skid_i       (ld_skid),
        .word_i          (word_inc),
        .out_o           (dn_data_o)
    );

    // R5
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_stb_o && dn_busy_i |=> dn_stb_o && $stable(dn_data_o));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_stb_i && !up_busy_o |=> dn_stb_o);

    // R3
    incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_stb_i && !up_busy_o && (!dn_stb_o || !dn_busy_i)
        |=> dn_data_o == DATA_W'($past(up_data_i) + 1'b1));

endmodule

// File: tb/sim_bp_skid_stage.sv
`timescale 1ns/1ps
module sim_bp_skid_stage;

    localparam int W      = 8;
    localparam int NWORDS = 3000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst_n, up_stb, dn_busy, up_busy, dn_stb;
    logic [W-1:0] up_data, dn_data;

    logic         c_stb, c_busy, c_ubusy, c_dstb, m_stb, m_busy;
    logic [W-1:0] c_data, c_out, m_data;

    int checks = 0;
    int errors = 0;

    bp_skid_stage #(.DATA_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .up_stb_i(up_stb), .up_data_i(up_data),
        .up_busy_o(up_busy), .dn_stb_o(dn_stb), .dn_data_o(dn_data),
        .dn_busy_i(dn_busy)
    );

    bp_skid_stage #(.DATA_W(W)) u_c1 (
        .clk(clk), .rst_n(rst_n), .up_stb_i(c_stb), .up_data_i(c_data),
        .up_busy_o(c_ubusy), .dn_stb_o(m_stb), .dn_data_o(m_data),
        .dn_busy_i(m_busy)
    );

    bp_skid_stage #(.DATA_W(W)) u_c2 (
        .clk(clk), .rst_n(rst_n), .up_stb_i(m_stb), .up_data_i(m_data),
        .up_busy_o(m_busy), .dn_stb_o(c_dstb), .dn_data_o(c_out),
        .dn_busy_i(c_busy)
    );

    typedef struct packed {
        logic         rst_n;
        logic         stb;
        logic [W-1:0] d;
        logic         busy;
        logic         e_stb;
        logic         e_ub;
        logic [W-1:0] e_d;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 8'h00}, // R1 reset
        '{1'b1, 1'b1, 8'h05, 1'b0, 1'b1, 1'b0, 8'h06}, // R2 R3 first word
        '{1'b1, 1'b1, 8'h07, 1'b0, 1'b1, 1'b0, 8'h08}, // R8 back to back
        '{1'b1, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b0, 8'h00}, // R3 wrap
        '{1'b1, 1'b1, 8'h09, 1'b1, 1'b1, 1'b1, 8'h00}, // R6 skid fills
        '{1'b1, 1'b1, 8'h0C, 1'b1, 1'b1, 1'b1, 8'h00}, // R5 R6 ignored
        '{1'b1, 1'b1, 8'h0D, 1'b0, 1'b1, 1'b0, 8'h0A}, // R7 skid moves up
        '{1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, // R4 drained
        '{1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, // R4 idle
        '{1'b1, 1'b1, 8'h20, 1'b1, 1'b1, 1'b0, 8'h21}, // R2 fill under busy
        '{1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h21}, // R5 held
        '{1'b1, 1'b1, 8'h30, 1'b0, 1'b1, 1'b0, 8'h31}, // R8 swap
        '{1'b1, 1'b1, 8'h40, 1'b1, 1'b1, 1'b1, 8'h31}, // R6 full again
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, // R1 reset when full
        '{1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}  // R1 nothing left
    };

    // Count one comparison; report a mismatch.
    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Advance one clock; return at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; up_stb = 1'b0; up_data = '0; dn_busy = 1'b0;
        c_stb = 1'b0; c_data = '0; c_busy = 1'b0;
        @(negedge clk);
        step();
        check("R1 strobe after reset", W'(dn_stb), W'(0));
        check("R1 busy after reset", W'(up_busy), W'(0));

        // Vector table walk.
        for (int v = 0; v < NV; v++) begin
            rst_n   = VEC[v].rst_n;
            up_stb  = VEC[v].stb;
            up_data = VEC[v].d;
            dn_busy = VEC[v].busy;
            step();
            check($sformatf("table %0d strobe", v), W'(dn_stb), W'(VEC[v].e_stb));
            check($sformatf("table %0d busy", v), W'(up_busy), W'(VEC[v].e_ub));
            if (VEC[v].e_stb)
                check($sformatf("table %0d data", v), dn_data, VEC[v].e_d);
        end

        // R9: two chained stages, two clocks of latency.
        rst_n = 1'b0; up_stb = 1'b0; dn_busy = 1'b0;
        step();
        rst_n  = 1'b1;
        c_stb  = 1'b1;
        c_data = 8'h05;
        step();
        c_stb = 1'b0;
        check("R9 chain strobe after one clock", W'(c_dstb), W'(0));
        step();
        check("R9 chain strobe after two clocks", W'(c_dstb), W'(1));
        check("R9 chain data", c_out, 8'h07);
        step();
        check("R9 chain drained", W'(c_dstb), W'(0));

        // R10: random stalls and gaps, scoreboard by order.
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        begin
            int sent = 0;
            int rcvd = 0;
            int lvl  = 0;
            int cyc  = 0;
            while (rcvd < NWORDS) begin
                if ((cyc % 16) == 0) lvl = $urandom_range(3);
                cyc++;
                dn_busy = (lvl != 0) && ($urandom_range(lvl) == 0);
                up_stb  = (sent < NWORDS) && ($urandom_range(4) != 0);
                up_data = W'(sent + 1);
                #1;
                if (up_stb && !up_busy) sent++;
                if (dn_stb && !dn_busy) begin
                    check("R10 random order", dn_data, W'(rcvd + 2));
                    rcvd++;
                end
                step();
            end
            dn_busy = 1'b0;
            up_stb  = 1'b0;
            step();
            check("R10 sent count", W'(sent), W'(NWORDS));
            check("R10 stage empty", W'(dn_stb), W'(0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule